// File: doc/BRIEF.md
# Microcoded Waveform Sequencer

This block steps through a short program of 14-bit instructions held in an internal program memory. It executes one instruction step for each pixel-clock enable. The program drives an 8-bit output level, a mux-select bit and a data-enable bit. These outputs are registered and change only on steps that set them. The instruction set has six groups. Output-setting instructions form one group. Two of them also mark the start of a loop. A SKIP holds the bus for a programmed number of pixels. Two independent counted loops, repeat and replay, jump back to their markers. The remaining instructions are an absolute jump, a park-in-place hold and a stop.

The program memory is loaded through a valid/ready write port. The port exerts back-pressure while the sequencer runs: `ld_ready` is low whenever `running` is high. A writer must keep `ld_valid`, `ld_addr` and `ld_data` steady until it sees `ld_ready` high at a clock edge. A word is written on each edge where both `ld_valid` and `ld_ready` are high. Start and stop are plain level inputs sampled on every clock. `running` and `error` report the state of the sequencer.

Top module: `wfm_sequencer`

## Requirements
- R1: An instruction word carries the opcode in bits 13:10 and the argument in bits 9:0. The opcodes are SET=0, RPTSET=1, RPLSET=2, SKIP=3, STOP=4, REPEAT=5, REPLAY=6, JUMP=7 and HOLD=8. For SET, RPTSET, RPLSET and HOLD, argument bits 7:0 give the level, bit 8 the mux select and bit 9 the data enable. A SET step loads these three outputs and advances to the next address, wrapping from 63 to 0.
- R2: After reset the outputs are zero, `running` and `error` are low and `ld_ready` is high.
- R3: `ld_ready` equals the inverse of `running`. A word offered while the sequencer runs is not written.
- R4: A `start` seen while halted, with `stop` low, sets `running`. It clears `error` and both loop states, and it makes the next step execute address 0. A `start` seen while running has no effect.
- R5: A step happens only on a cycle where `pix_en` is high and the sequencer is running. With `pix_en` low the outputs and the program position do not change.
- R6: SKIP n with n from 1 to 1023 leaves the outputs unchanged for n+1 steps, counting its own step. The next step executes the following address.
- R7: RPTSET behaves as SET and also records its own address as the repeat-loop start. REPEAT n jumps back to that start until the segment has run n more times, and then falls through. REPEAT 0 falls through at once.
- R8: RPLSET and REPLAY behave as R7 but use a separate replay-loop register and counter. The two loops can therefore nest.
- R9: JUMP with argument bit 6 set continues at the address in argument bits 5:0.
- R10: HOLD loads the outputs like SET and then keeps re-executing itself until the sequencer is stopped.
- R11: STOP clears `running`. While halted the outputs keep their last values.
- R12: Some instructions stop the sequencer and set `error`: an opcode of 9 to 15, a SKIP with a zero count, and a JUMP with argument bit 6 clear. `error` then stays set until the next accepted start.
- R13: The `stop` input clears `running` on the next edge, whatever `pix_en` is. It takes priority over `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable; one step per high cycle |
| start | input | 1 | Begin execution at address 0 when halted |
| stop | input | 1 | Halt execution |
| ld_valid | input | 1 | Program write offered |
| ld_ready | output | 1 | Program write accepted (sequencer halted) |
| ld_addr | input | 6 | Program write address |
| ld_data | input | 14 | Program write instruction word |
| out_level | output | 8 | Output level |
| out_mux | output | 1 | Mux-select output |
| out_de | output | 1 | Data-enable output |
| running | output | 1 | Sequencer executing |
| error | output | 1 | Halted on an illegal instruction |

## Verification
The bench sweeps SKIP counts from 1 to 8. A design with an off-by-one in the hold counter shows the next level one pixel early or late. Replay counts from 0 to 3 are swept under a gapped pixel enable, and a nested repeat around a replay is run. A design that shares the two loop counters, or that mishandles a zero count, produces the wrong number of output pulses. Every illegal opcode, a zero SKIP and a JUMP with bit 6 clear are each tried, and each must halt with `error` set rather than run on. Writes are offered during a run and a start is issued mid-program; the program position and the memory contents afterwards reveal any write or restart that got through.

// File: rtl/wfm_pkg.sv
package wfm_pkg;
  localparam int OPW      = 4;
  localparam int ARGW     = 10;
  localparam int INSW     = OPW + ARGW;
  localparam int LVLW     = 8;
  localparam int MUX_BIT  = 8;
  localparam int DE_BIT   = 9;
  localparam int JFLAG    = 6;

  typedef enum logic [OPW-1:0] {
    OP_SET    = 4'd0,
    OP_RPTSET = 4'd1,
    OP_RPLSET = 4'd2,
    OP_SKIP   = 4'd3,
    OP_STOP   = 4'd4,
    OP_REPEAT = 4'd5,
    OP_REPLAY = 4'd6,
    OP_JUMP   = 4'd7,
    OP_HOLD   = 4'd8
  } op_e;
endpackage

// File: rtl/wfm_progmem.sv
module wfm_progmem #(
  parameter int AW = 6,
  parameter int W  = 14
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/wfm_loop.sv
module wfm_loop #(
  parameter int AW = 6,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          mark,
  input  logic [AW-1:0] here,
  input  logic          eval,
  input  logic [CW-1:0] count,
  output logic          taken,
  output logic [AW-1:0] target
);
  logic          busy;
  logic [CW-1:0] left;
  logic [AW-1:0] anchor;

  assign taken  = eval && (busy ? (left != '0) : (count != '0));
  assign target = anchor;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      busy   <= 1'b0;
      left   <= '0;
      anchor <= '0;
    end else begin
      if (mark) anchor <= here;
      if (eval) begin
        if (!busy) begin
          if (count != '0) begin
            busy <= 1'b1;
            left <= count - 1'b1;
          end
        end else if (left == '0) begin
          busy <= 1'b0;
        end else begin
          left <= left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wfm_core.sv
module wfm_core
  import wfm_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_en,
  input  logic            start,
  input  logic            stop,
  input  logic [INSW-1:0] instr,
  output logic [AW-1:0]   pc,
  output logic [LVLW-1:0] level,
  output logic            mux,
  output logic            de,
  output logic            running,
  output logic            error
);
  localparam int NLOOP = 2;

  logic [OPW-1:0]  opc;
  logic [ARGW-1:0] arg;
  logic            step;
  logic            launch;
  logic [AW-1:0]   pc_next;
  logic            skip_busy;
  logic [ARGW-1:0] skip_left;

  logic [NLOOP-1:0] l_mark;
  logic [NLOOP-1:0] l_eval;
  logic [NLOOP-1:0] l_taken;
  logic [AW-1:0]    l_target [NLOOP];

  assign opc     = instr[INSW-1:ARGW];
  assign arg     = instr[ARGW-1:0];
  assign step    = running && pix_en && !stop;
  assign launch  = start && !running && !stop;
  assign pc_next = pc + 1'b1;

  // loop 0 is the repeat loop, loop 1 the replay loop
  for (genvar gi = 0; gi < NLOOP; gi++) begin : g_loop
    localparam op_e MARK_OP = (gi == 0) ? OP_RPTSET : OP_RPLSET;
    localparam op_e EVAL_OP = (gi == 0) ? OP_REPEAT : OP_REPLAY;
    assign l_mark[gi] = step && (opc == MARK_OP);
    assign l_eval[gi] = step && (opc == EVAL_OP);
    wfm_loop #(.AW(AW), .CW(ARGW)) u_loop (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (launch),
      .mark   (l_mark[gi]),
      .here   (pc),
      .eval   (l_eval[gi]),
      .count  (arg),
      .taken  (l_taken[gi]),
      .target (l_target[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      level     <= '0;
      mux       <= 1'b0;
      de        <= 1'b0;
      running   <= 1'b0;
      error     <= 1'b0;
      skip_busy <= 1'b0;
      skip_left <= '0;
    end else if (stop) begin
      running <= 1'b0;
    end else if (launch) begin
      running   <= 1'b1;
      error     <= 1'b0;
      pc        <= '0;
      skip_busy <= 1'b0;
    end else if (step) begin
      case (opc)
        OP_SET, OP_RPTSET, OP_RPLSET, OP_HOLD: begin
          level <= arg[LVLW-1:0];
          mux   <= arg[MUX_BIT];
          de    <= arg[DE_BIT];
          if (opc != OP_HOLD) pc <= pc_next;
        end
        OP_SKIP: begin
          if (arg == '0) begin
            running <= 1'b0;
            error   <= 1'b1;
          end else if (!skip_busy) begin
            skip_busy <= 1'b1;
            skip_left <= arg;
          end else if (skip_left == ARGW'(1)) begin
            skip_busy <= 1'b0;
            pc        <= pc_next;
          end else begin
            skip_left <= skip_left - 1'b1;
          end
        end
        OP_REPEAT: pc <= l_taken[0] ? l_target[0] : pc_next;
        OP_REPLAY: pc <= l_taken[1] ? l_target[1] : pc_next;
        OP_JUMP: begin
          if (arg[JFLAG]) begin
            pc <= arg[AW-1:0];
          end else begin
            running <= 1'b0;
            error   <= 1'b1;
          end
        end
        OP_STOP: running <= 1'b0;
        default: begin
          running <= 1'b0;
          error   <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/wfm_sequencer.sv
module wfm_sequencer
  import wfm_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_en,
  input  logic            start,
  input  logic            stop,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic [AW-1:0]   ld_addr,
  input  logic [INSW-1:0] ld_data,
  output logic [LVLW-1:0] out_level,
  output logic            out_mux,
  output logic            out_de,
  output logic            running,
  output logic            error
);
  logic [AW-1:0]   pc;
  logic [INSW-1:0] instr;

  assign ld_ready = !running;

  wfm_progmem #(.AW(AW), .W(INSW)) u_mem (
    .clk   (clk),
    .we    (ld_valid && ld_ready),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (pc),
    .rdata (instr)
  );

  wfm_core #(.AW(AW)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_en  (pix_en),
    .start   (start),
    .stop    (stop),
    .instr   (instr),
    .pc      (pc),
    .level   (out_level),
    .mux     (out_mux),
    .de      (out_de),
    .running (running),
    .error   (error)
  );
endmodule

// File: rtl/wfm_sequencer_chk.sv
module wfm_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_en,
  input logic       start,
  input logic       stop,
  input logic [7:0] out_level,
  input logic       out_mux,
  input logic       out_de,
  input logic       running,
  input logic       error
);
  // R13
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !running);

  // R4
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !running && !stop) |=> (running && !error));

  // R4
  run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(start));

  // R5
  no_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable({out_level, out_mux, out_de}));

  // R11
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable({out_level, out_mux, out_de}));

  // R12
  error_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> !running);

  // R12
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);
endmodule

bind wfm_sequencer wfm_sequencer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_en    (pix_en),
  .start     (start),
  .stop      (stop),
  .out_level (out_level),
  .out_mux   (out_mux),
  .out_de    (out_de),
  .running   (running),
  .error     (error)
);

// File: tb/sim_wfm_sequencer.sv
module sim_wfm_sequencer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, pix_en, start, stop, ld_valid, ld_ready;
  logic [5:0]  ld_addr;
  logic [13:0] ld_data;
  logic [7:0]  out_level;
  logic        out_mux, out_de, running, error;

  wfm_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .start(start), .stop(stop),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_data(ld_data), .out_level(out_level), .out_mux(out_mux),
    .out_de(out_de), .running(running), .error(error)
  );

  int checks = 0;
  int errors = 0;
  string req = "R2";
  logic [13:0] mem [64];

  // reference state derived from the requirements
  logic [5:0] m_pc;
  logic [7:0] m_lvl;
  logic       m_mux, m_de, m_run, m_err;
  logic       m_sb;
  int         m_sl;
  logic       m_lb [2];
  int         m_ll [2];
  logic [5:0] m_ls [2];

  function automatic logic [13:0] ins(input logic [3:0] op, input logic [9:0] a);
    return {op, a};
  endfunction

  function automatic logic [9:0] drv(input int lvl, input bit mx, input bit d);
    return {d, mx, lvl[7:0]};
  endfunction

  task automatic check(input string r, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (level,mux,de,run,err,ready)", r, act, exp);
    end
  endtask

  task automatic set_err();
    m_run = 1'b0;
    m_err = 1'b1;
  endtask

  task automatic model_exec();
    logic [13:0] w;
    logic [3:0]  op;
    logic [9:0]  a;
    int k;
    w  = mem[m_pc];
    op = w[13:10];
    a  = w[9:0];
    case (op)
      4'd0, 4'd1, 4'd2, 4'd8: begin
        m_lvl = a[7:0]; m_mux = a[8]; m_de = a[9];
        if (op == 4'd1) m_ls[0] = m_pc;
        if (op == 4'd2) m_ls[1] = m_pc;
        if (op != 4'd8) m_pc = m_pc + 6'd1;
      end
      4'd3: begin
        if (a == 10'd0) set_err();
        else if (!m_sb) begin m_sb = 1'b1; m_sl = int'(a); end
        else if (m_sl == 1) begin m_sb = 1'b0; m_pc = m_pc + 6'd1; end
        else m_sl--;
      end
      4'd5, 4'd6: begin
        k = (op == 4'd5) ? 0 : 1;
        if (!m_lb[k]) begin
          if (a == 10'd0) m_pc = m_pc + 6'd1;
          else begin m_lb[k] = 1'b1; m_ll[k] = int'(a) - 1; m_pc = m_ls[k]; end
        end else if (m_ll[k] == 0) begin
          m_lb[k] = 1'b0; m_pc = m_pc + 6'd1;
        end else begin
          m_ll[k]--; m_pc = m_ls[k];
        end
      end
      4'd7: if (a[6]) m_pc = a[5:0]; else set_err();
      4'd4: m_run = 1'b0;
      default: set_err();
    endcase
  endtask

  task automatic tick(input bit pe, input bit st, input bit sp,
                      input bit lv, input logic [5:0] la, input logic [13:0] ld);
    pix_en = pe; start = st; stop = sp; ld_valid = lv; ld_addr = la; ld_data = ld;
    @(posedge clk);
    if (lv && !m_run) mem[la] = ld;
    if (sp) m_run = 1'b0;
    else if (st && !m_run) begin
      m_run = 1'b1; m_err = 1'b0; m_pc = 6'd0; m_sb = 1'b0;
      for (int i = 0; i < 2; i++) begin m_lb[i] = 1'b0; m_ll[i] = 0; m_ls[i] = 6'd0; end
    end else if (m_run && pe) model_exec();
    #1;
    check(req, {out_level, out_mux, out_de, running, error, ld_ready},
          {m_lvl, m_mux, m_de, m_run, m_err, !m_run});
    ld_valid = 1'b0; start = 1'b0; stop = 1'b0;
  endtask

  task automatic load(input int a, input logic [13:0] w);
    tick(1'b0, 1'b0, 1'b0, 1'b1, 6'(a), w);
  endtask

  task automatic go();
    tick(1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 14'd0);
  endtask

  task automatic halt();
    tick(1'b0, 1'b0, 1'b1, 1'b0, 6'd0, 14'd0);
  endtask

  // gap: 0 = enable every cycle, otherwise enable low on every gap-th cycle
  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++)
      tick((gap == 0) || ((i % gap) != gap - 1), 1'b0, 1'b0, 1'b0, 6'd0, 14'd0);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_en = 1'b0; start = 1'b0; stop = 1'b0;
    ld_valid = 1'b0; ld_addr = '0; ld_data = '0;
    m_pc = '0; m_lvl = '0; m_mux = 1'b0; m_de = 1'b0; m_run = 1'b0; m_err = 1'b0;
    m_sb = 1'b0; m_sl = 0;
    for (int i = 0; i < 2; i++) begin m_lb[i] = 1'b0; m_ll[i] = 0; m_ls[i] = '0; end
    for (int i = 0; i < 64; i++) mem[i] = 14'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    req = "R2";
    check(req, {out_level, out_mux, out_de, running, error, ld_ready}, 13'h001);

    // R1: sweep of SET patterns across the whole memory, then STOP
    req = "R1";
    for (int i = 0; i < 63; i++) load(i, ins(4'd0, drv(i * 4 + 1, i[0], i[1])));
    load(63, ins(4'd4, 10'd0));
    go();
    run(70, 0);

    // R11: halted outputs remain after STOP
    req = "R11";
    run(4, 0);

    // R6: SKIP counts 1..8 with a marker level on each side
    req = "R6";
    for (int n = 1; n <= 8; n++) begin
      load(0, ins(4'd0, drv(8'h10 + n, 1'b1, 1'b0)));
      load(1, ins(4'd3, 10'(n)));
      load(2, ins(4'd0, drv(8'hA0 + n, 1'b0, 1'b1)));
      load(3, ins(4'd4, 10'd0));
      go();
      run(n + 6, 0);
    end

    // R8 and R5: replay counts 0..3 under a gapped pixel enable
    for (int n = 0; n <= 3; n++) begin
      req = "R8";
      load(0, ins(4'd2, drv(8'h33, 1'b0, 1'b1)));
      load(1, ins(4'd0, drv(8'h44, 1'b1, 1'b0)));
      load(2, ins(4'd6, 10'(n)));
      load(3, ins(4'd0, drv(8'h55, 1'b0, 1'b0)));
      load(4, ins(4'd4, 10'd0));
      go();
      req = "R5";
      run(4 * n + 12, 3);
    end

    // R7: repeat loop enclosing a replay loop
    req = "R7";
    load(0, ins(4'd1, drv(8'h01, 1'b0, 0)));
    load(1, ins(4'd2, drv(8'h02, 1'b1, 0)));
    load(2, ins(4'd0, drv(8'h03, 1'b0, 1)));
    load(3, ins(4'd6, 10'd2));
    load(4, ins(4'd5, 10'd2));
    load(5, ins(4'd3, 10'd2));
    load(6, ins(4'd4, 10'd0));
    go();
    run(40, 0);

    // R9: JUMP over a skipped instruction
    req = "R9";
    load(0, ins(4'd0, drv(8'h61, 1'b0, 0)));
    load(1, ins(4'd7, 10'h040 | 10'd5));
    load(2, ins(4'd0, drv(8'hEE, 1'b1, 1)));
    load(5, ins(4'd0, drv(8'h65, 1'b1, 0)));
    load(6, ins(4'd4, 10'd0));
    go();
    run(8, 0);

    // R10 then R13: HOLD parks until stop; stop with pix_en low
    req = "R10";
    load(0, ins(4'd8, drv(8'h77, 1'b1, 1)));
    load(1, ins(4'd0, drv(8'h88, 1'b0, 0)));
    load(2, ins(4'd4, 10'd0));
    go();
    run(10, 0);
    req = "R13";
    halt();
    run(3, 0);
    // stop and start together: stop wins
    tick(1'b1, 1'b1, 1'b1, 1'b0, 6'd0, 14'd0);
    run(2, 0);

    // R3: writes offered while running are refused
    req = "R3";
    go();
    run(2, 0);
    load(0, ins(4'd0, drv(8'h22, 0, 0)));
    load(1, ins(4'd4, 10'd0));
    halt();
    go();
    run(4, 0);
    halt();

    // R4: start while running is ignored
    req = "R4";
    for (int i = 0; i < 5; i++) load(i, ins(4'd0, drv(8'hC0 + i, i[0], 1)));
    load(5, ins(4'd4, 10'd0));
    go();
    run(2, 0);
    go();
    run(6, 0);

    // R12: illegal opcodes, SKIP 0, JUMP without bit 6
    req = "R12";
    for (int op = 9; op < 16; op++) begin
      load(0, ins(4'(op), 10'd0));
      load(1, ins(4'd0, drv(8'h99, 0, 1)));
      go();
      run(3, 0);
    end
    load(0, ins(4'd3, 10'd0));
    go();
    run(3, 0);
    load(0, ins(4'd7, 10'd3));
    go();
    run(3, 0);
    load(0, ins(4'd0, drv(8'h5A, 1, 1)));
    load(1, ins(4'd4, 10'd0));
    go();
    run(3, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule